// File: doc/BRIEF.md
# Read-Sequence Store Trigger

This block sits beside a byte-wide memory of 2048 locations and watches the stream of accesses. It recognises one fixed chain of six reads. When it sees the whole chain, it asks the nonvolatile controller to save the array. The command travels over the ordinary address bus, so no extra pins are needed. Each read in the chain is still a normal read, and the memory returns its data as usual. The detector only observes the bus and never blocks an access.

Each access arrives as a registered strobe, together with a write flag and an 11-bit address. The chain must be made of reads to 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and 0x70F, in exactly that order. Idle cycles may fall between two steps without harm. Any other access breaks the chain: a write, or a read to any address other than the one expected next. When the final read lands, the block raises a store request for one cycle and returns to its idle state. While the nonvolatile engine reports busy, the detector stays idle and ignores the bus. The order of the six addresses is itself the behaviour, so it is kept.

Top module: `sst_store_detect`

## Requirements
- R1: On reset, and after it is released, store_req is 0 and no step of the chain counts as seen. A reset in the middle of a chain discards the progress made so far.
- R2: Six accesses with acc_write=0 to 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and 0x70F, in that order, drive store_req to 1 in the clock cycle after the sixth access is sampled.
- R3: store_req is high for exactly one cycle. The chain then restarts from idle, so a lone read of 0x70F afterwards does not raise it.
- R4: A write (acc_write=1) in the middle of a chain aborts it, even when it targets the expected address. The remaining reads of that chain then raise nothing.
- R5: A read to an address other than the next expected one aborts the chain.
- R6: A read of 0x000 that breaks a chain counts as the first step of a new chain. The five reads that follow it then complete the chain.
- R7: While nv_busy is 1, accesses are ignored, any partial chain is cleared and store_req stays 0.
- R8: Cycles with acc_valid=0 leave the progress unchanged, so gaps between steps are allowed.
- R9: The request is raised whether or not any write happened before the chain.
- R10: A write to 0x70F after the first five correct reads does not raise store_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | One access is present on this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 11 | Byte address of the access |
| nv_busy | input | 1 | Nonvolatile cycle in progress |
| store_req | output | 1 | One-cycle request to save the array |

## Verification
Every result comes from a single register stage. The effect of an access sampled at a rising edge therefore shows up on store_req straight after that edge, and the bench drives on the falling edge and checks store_req on the next falling edge. Progress is not visible at the ports, so each abort, restart and hold case is judged by whether the reads that follow it do or do not raise the request on that same one-cycle schedule. Reset release passes through two synchroniser flops, and the bench waits three cycles before its first access.

// File: rtl/sst_pkg.sv
package sst_pkg;
  parameter int unsigned SST_ADDR_W  = 11;
  parameter int unsigned SST_N_STEPS = 6;
  // step i occupies bits [i*SST_ADDR_W +: SST_ADDR_W]; first step in the low slice
  parameter logic [SST_N_STEPS*SST_ADDR_W-1:0] SST_DEF_PATTERN =
    {11'h70F, 11'h0F0, 11'h7FF, 11'h2AA, 11'h555, 11'h000};
endpackage

// File: rtl/sst_rst_sync.sv
module sst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sst_step_match.sv
module sst_step_match #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned N_STEPS = 6,
  parameter logic [N_STEPS*ADDR_W-1:0] PATTERN = '0,
  localparam int unsigned PW = $clog2(N_STEPS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PW-1:0]     prog_i,
  output logic              hit_exp_o,
  output logic              hit_first_o
);
  logic [N_STEPS-1:0] hit_vec;
  logic [N_STEPS-1:0] sel_vec;

  for (genvar i = 0; i < N_STEPS; i++) begin : g_step
    assign hit_vec[i] = (addr_i == PATTERN[i*ADDR_W +: ADDR_W]);
    assign sel_vec[i] = (prog_i == PW'(i));
  end

  assign hit_exp_o   = |(hit_vec & sel_vec);
  assign hit_first_o = hit_vec[0];
endmodule

// File: rtl/sst_tracker.sv
module sst_tracker #(
  parameter int unsigned N_STEPS = 6,
  localparam int unsigned PW = $clog2(N_STEPS)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          acc_valid_i,
  input  logic          acc_write_i,
  input  logic          busy_i,
  input  logic          hit_exp_i,
  input  logic          hit_first_i,
  output logic [PW-1:0] prog_o,
  output logic          fire_o
);
  localparam logic [PW-1:0] LAST_IDX = PW'(N_STEPS - 1);
  localparam logic [PW-1:0] ONE      = PW'(1);

  logic [PW-1:0] prog_q, prog_d;
  logic          fire_q, fire_d;
  logic          rd_access;

  assign rd_access = acc_valid_i && !acc_write_i && !busy_i;

  always_comb begin
    prog_d = prog_q;
    fire_d = 1'b0;
    if (busy_i) begin
      prog_d = '0;
    end else if (acc_valid_i) begin
      if (rd_access && hit_exp_i) begin
        if (prog_q == LAST_IDX) begin
          prog_d = '0;
          fire_d = 1'b1;
        end else begin
          prog_d = prog_q + ONE;
        end
      end else if (rd_access && hit_first_i) begin
        prog_d = ONE;
      end else begin
        prog_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q <= '0;
      fire_q <= 1'b0;
    end else begin
      prog_q <= prog_d;
      fire_q <= fire_d;
    end
  end

  assign prog_o = prog_q;
  assign fire_o = fire_q;

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_q |=> !fire_q);
  a_r3_idle_after_fire: assert property (@(posedge clk) disable iff (!rst_ni)
    fire_q |-> prog_q == '0);
  a_r7_busy_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_i |=> (prog_q == '0) && !fire_q);
  a_r4_write_aborts: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> (prog_q == '0) && !fire_q);
  a_r6_restart_step2: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_access && hit_first_i && (prog_q != LAST_IDX || !hit_exp_i)) |=> prog_q == ONE);
  a_r8_gap_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    (!acc_valid_i && !busy_i) |=> $stable(prog_q) && !fire_q);
  a_r2_range: assert property (@(posedge clk) disable iff (!rst_ni)
    prog_q <= LAST_IDX);
endmodule

// File: rtl/sst_store_detect.sv
module sst_store_detect #(
  parameter int unsigned ADDR_W  = sst_pkg::SST_ADDR_W,
  parameter int unsigned N_STEPS = sst_pkg::SST_N_STEPS,
  parameter logic [N_STEPS*ADDR_W-1:0] PATTERN = sst_pkg::SST_DEF_PATTERN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              nv_busy,
  output logic              store_req
);
  localparam int unsigned PW = $clog2(N_STEPS);
  localparam logic [ADDR_W-1:0] LAST_ADDR = PATTERN[(N_STEPS-1)*ADDR_W +: ADDR_W];

  logic          rst_ni;
  logic [PW-1:0] prog;
  logic          hit_exp;
  logic          hit_first;

  sst_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  sst_step_match #(
    .ADDR_W  (ADDR_W),
    .N_STEPS (N_STEPS),
    .PATTERN (PATTERN)
  ) u_match (
    .addr_i      (acc_addr),
    .prog_i      (prog),
    .hit_exp_o   (hit_exp),
    .hit_first_o (hit_first)
  );

  sst_tracker #(.N_STEPS(N_STEPS)) u_track (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid),
    .acc_write_i (acc_write),
    .busy_i      (nv_busy),
    .hit_exp_i   (hit_exp),
    .hit_first_i (hit_first),
    .prog_o      (prog),
    .fire_o      (store_req)
  );

  a_r2_fire_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    store_req |-> $past(acc_valid && !acc_write && !nv_busy && acc_addr == LAST_ADDR));
  a_r7_no_fire_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    nv_busy |=> !store_req);
  a_r10_write_last: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_valid && acc_write) |=> !store_req);
endmodule

// File: tb/sst_store_detect_tb.sv
module sst_store_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [10:0] acc_addr = '0;
  logic        nv_busy = 1'b0;
  logic        store_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sst_store_detect u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .nv_busy   (nv_busy),
    .store_req (store_req)
  );

  // entry: {req_tag[3:0], valid, write, busy, addr[10:0], expected store_req}
  localparam int NV = 53;
  localparam logic [18:0] VEC [0:NV-1] = '{
    // R2 full chain
    {4'd2,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd2,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd2,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd2,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd2,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd2,1'b1,1'b0,1'b0,11'h70F,1'b1},
    // R3 pulse ends, lone last read does nothing
    {4'd3,1'b0,1'b0,1'b0,11'h000,1'b0}, {4'd3,1'b1,1'b0,1'b0,11'h70F,1'b0},
    // R8 gaps between steps
    {4'd8,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd8,1'b0,1'b0,1'b0,11'h123,1'b0},
    {4'd8,1'b1,1'b0,1'b0,11'h555,1'b0}, {4'd8,1'b0,1'b1,1'b0,11'h000,1'b0},
    {4'd8,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd8,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd8,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd8,1'b0,1'b0,1'b0,11'h70F,1'b0},
    {4'd8,1'b1,1'b0,1'b0,11'h70F,1'b1},
    // R4 write to expected address aborts
    {4'd4,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd4,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd4,1'b1,1'b1,1'b0,11'h2AA,1'b0}, {4'd4,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd4,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd4,1'b1,1'b0,1'b0,11'h70F,1'b0},
    // R5 stray read aborts
    {4'd5,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd5,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd5,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd5,1'b1,1'b0,1'b0,11'h123,1'b0},
    {4'd5,1'b1,1'b0,1'b0,11'h7FF,1'b0}, {4'd5,1'b1,1'b0,1'b0,11'h0F0,1'b0},
    {4'd5,1'b1,1'b0,1'b0,11'h70F,1'b0},
    // R6 aborting read of 0x000 restarts at step 2
    {4'd6,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd6,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd6,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd6,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd6,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd6,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd6,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd6,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd6,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd6,1'b1,1'b0,1'b0,11'h70F,1'b1},
    // R10 write to last address
    {4'd10,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd10,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd10,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd10,1'b1,1'b0,1'b0,11'h7FF,1'b0},
    {4'd10,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd10,1'b1,1'b1,1'b0,11'h70F,1'b0},
    {4'd10,1'b1,1'b0,1'b0,11'h70F,1'b0},
    // R7 busy mid-chain clears progress
    {4'd7,1'b1,1'b0,1'b0,11'h000,1'b0}, {4'd7,1'b1,1'b0,1'b0,11'h555,1'b0},
    {4'd7,1'b1,1'b0,1'b0,11'h2AA,1'b0}, {4'd7,1'b1,1'b0,1'b1,11'h7FF,1'b0},
    {4'd7,1'b1,1'b0,1'b0,11'h0F0,1'b0}, {4'd7,1'b1,1'b0,1'b0,11'h70F,1'b0}
  };

  localparam logic [10:0] SEQ [0:5] = '{11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0, 11'h70F};

  task automatic check(input int tag, input logic exp, input int idx);
    checks++;
    if (store_req !== exp) begin
      errors++;
      $display("FAIL R%0d: store_req=%0b expected %0b (step %0d)", tag, store_req, exp, idx);
    end
  endtask

  task automatic access(input logic v, input logic w, input logic b, input logic [10:0] a);
    acc_valid = v; acc_write = w; nv_busy = b; acc_addr = a;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; nv_busy = 1'b0;
  endtask

  task automatic run_seq(input int tag, input logic busy, input logic exp_last);
    for (int k = 0; k < 6; k++) begin
      access(1'b1, 1'b0, busy, SEQ[k]);
      check(tag, (k == 5) ? exp_last : 1'b0, 1000 + k);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(1, 1'b0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, 1'b0, 1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:1]);
      check(int'(VEC[i][18:15]), VEC[i][0], i);
    end

    // R1 reset in the middle of a chain discards progress
    for (int k = 0; k < 5; k++) access(1'b1, 1'b0, 1'b0, SEQ[k]);
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 2000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b1, 1'b0, 1'b0, 11'h70F);
    check(1, 1'b0, 2001);

    // R9 writes before the chain do not matter
    access(1'b1, 1'b1, 1'b0, 11'h555);
    access(1'b1, 1'b1, 1'b0, 11'h000);
    run_seq(9, 1'b0, 1'b1);

    // R7 whole chain while busy: nothing
    run_seq(7, 1'b1, 1'b0);
    // R7 busy with no access still clears progress
    for (int k = 0; k < 3; k++) access(1'b1, 1'b0, 1'b0, SEQ[k]);
    access(1'b0, 1'b0, 1'b1, 11'h000);
    for (int k = 3; k < 6; k++) begin
      access(1'b1, 1'b0, 1'b0, SEQ[k]);
      check(7, 1'b0, 3000 + k);
    end

    // R6 repeated 0x000 keeps step 2 armed; R3 back-to-back chains both fire
    access(1'b1, 1'b0, 1'b0, 11'h000);
    run_seq(6, 1'b0, 1'b1);
    run_seq(3, 1'b0, 1'b1);
    @(negedge clk);
    check(3, 1'b0, 4000);

    finish_run();
  end
endmodule